// File: doc/BRIEF.md
# Dual-slot instruction word dispatcher

The dispatcher accepts one 32-bit fetched instruction word at a time and turns it into a series of operations for an execution unit. The top two bits of the word choose the format. The word can be one long operation over bits 29:0. It can also be a pair of 15-bit short operations, called the left slot (bits 29:15) and the right slot (bits 14:0). A pair runs in a fixed order, right before left or left before right. It can also run as a parallel pair, in which one slot may be a condition test that gates its partner.

An upstream predecoder marks which short slots hold a condition-test-only operation. Each operation goes out over a valid/ready handshake with a slot tag. The dispatcher then waits for the execution unit's completion pulse before it does anything else. The pulse carries three result flags: the program counter moved, an exception was raised, and the condition result. These flags decide whether the second slot of a pair is issued. Four saturating statistics counters track fetched-word cycles, branch-taken skips, and the true and false outcomes of condition tests.

Top module: `slot_dispatcher`

## Requirements
- R1: While reset is asserted and in the first cycle after it, word_ready is 1, op_valid is 0 and all four counters read 0.
- R2: Format 2'b11 (word_data[31:30]) issues exactly one operation with op_tag 2'b11 and op_bits equal to word_data[29:0]. A short operation uses op_tag 2'b01 for the left slot (word bits 29:15) and 2'b10 for the right slot (word bits 14:0), with op_bits holding the 15-bit field zero-extended.
- R3: Format 2'b10 issues the right slot first and then the left slot.
- R4: Format 2'b01 issues the left slot first and then the right slot.
- R5: In formats 2'b10 and 2'b01, the second slot is not issued when the first slot's completion reports a PC change or an exception. cnt_taken_skip increments when that completion reports a PC change without an exception.
- R6: In format 2'b00 with at least one test-marked slot, the test slot is issued first, and the left slot wins when both slots are marked. Its partner is issued only if the completion reports the condition true. cnt_cond_true increments on a true result and cnt_cond_false on a false one.
- R7: In format 2'b00 with no test-marked slot, the left slot is issued first. The right slot is issued unless the left completion reports an exception. A PC change alone does not suppress it.
- R8: cnt_cycles increments by one when a word is accepted. It increments by one more at the first slot's completion of a format 2'b10 or 2'b01 word when the second slot is going to be issued.
- R9: Only one operation is outstanding at a time. While op_valid is 1 and op_ready is 0, op_tag and op_bits hold steady. word_ready is 1 only when no operation is pending or outstanding, and never together with op_valid.
- R10: Every counter stops at its all-ones value and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Fetched word is offered |
| word_ready | output | 1 | Dispatcher can take a word |
| word_data | input | 32 | Fetched instruction word |
| word_ltest | input | 1 | Left slot holds a condition-test-only operation |
| word_rtest | input | 1 | Right slot holds a condition-test-only operation |
| op_valid | output | 1 | Operation offered to the execution unit |
| op_ready | input | 1 | Execution unit takes the operation |
| op_tag | output | 2 | 01 left, 10 right, 11 long |
| op_bits | output | 30 | Operation field, short fields zero-extended |
| exec_done | input | 1 | Completion pulse for the outstanding operation |
| exec_pc_changed | input | 1 | Completed operation moved the PC |
| exec_exception | input | 1 | Completed operation raised an exception |
| exec_cond_true | input | 1 | Completed test operation evaluated true |
| cnt_cycles | output | CNT_W | Cycle statistic |
| cnt_taken_skip | output | CNT_W | Second slots skipped because of a PC change |
| cnt_cond_true | output | CNT_W | Test results that were true |
| cnt_cond_false | output | CNT_W | Test results that were false |

## Verification
The properties assume that the execution unit pulses exec_done once per accepted operation, only after the handshake and never while nothing is outstanding, and that it presents the result flags in that same cycle. They also assume that word_data and the test marks stay steady while word_valid is waiting. In the bench, the modelled execution unit raises its single-cycle completion only after it has seen a handshake, and it derives the flags from the low three bits of the operation it took. The word driver holds each word until word_ready accepts it.

// File: rtl/slot_dispatcher.sv
module slot_dispatcher #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_valid,
  output logic             word_ready,
  input  logic [31:0]      word_data,
  input  logic             word_ltest,
  input  logic             word_rtest,
  output logic             op_valid,
  input  logic             op_ready,
  output logic [1:0]       op_tag,
  output logic [29:0]      op_bits,
  input  logic             exec_done,
  input  logic             exec_pc_changed,
  input  logic             exec_exception,
  input  logic             exec_cond_true,
  output logic [CNT_W-1:0] cnt_cycles,
  output logic [CNT_W-1:0] cnt_taken_skip,
  output logic [CNT_W-1:0] cnt_cond_true,
  output logic [CNT_W-1:0] cnt_cond_false
);
  localparam logic [1:0] FMT_PAR  = 2'b00;
  localparam logic [1:0] FMT_LR   = 2'b01;
  localparam logic [1:0] FMT_RL   = 2'b10;
  localparam logic [1:0] FMT_LONG = 2'b11;
  localparam logic [1:0] TAG_LEFT  = 2'b01;
  localparam logic [1:0] TAG_RIGHT = 2'b10;
  localparam logic [1:0] TAG_LONG  = 2'b11;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t      state;
  logic [29:0] word_q;
  logic [1:0]  fmt_q;
  logic        ltest_q, rtest_q, second_q;

  logic accept, seq_fmt, par_test, right_first, cur_right;
  logic first_done, go_second;
  logic inc_cyc, inc_skip, inc_true, inc_false;

  assign word_ready  = (state == S_IDLE);
  assign op_valid    = (state == S_ISSUE);
  assign accept      = word_valid && word_ready;
  assign seq_fmt     = (fmt_q == FMT_LR) || (fmt_q == FMT_RL);
  assign par_test    = (fmt_q == FMT_PAR) && (ltest_q || rtest_q);
  assign right_first = (fmt_q == FMT_RL) || (par_test && !ltest_q);
  assign cur_right   = second_q ? !right_first : right_first;

  assign op_tag  = (fmt_q == FMT_LONG) ? TAG_LONG : (cur_right ? TAG_RIGHT : TAG_LEFT);
  assign op_bits = (fmt_q == FMT_LONG) ? word_q :
                   {15'd0, cur_right ? word_q[14:0] : word_q[29:15]};

  assign first_done = (state == S_WAIT) && exec_done && !second_q;

  always_comb begin
    case (fmt_q)
      FMT_LONG: go_second = 1'b0;
      FMT_LR, FMT_RL: go_second = !exec_pc_changed && !exec_exception;
      default: go_second = par_test ? exec_cond_true : !exec_exception;
    endcase
  end

  assign inc_cyc   = accept || (first_done && seq_fmt && go_second);
  assign inc_skip  = first_done && seq_fmt && exec_pc_changed && !exec_exception;
  assign inc_true  = first_done && par_test && exec_cond_true;
  assign inc_false = first_done && par_test && !exec_cond_true;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      word_q   <= '0;
      fmt_q    <= FMT_LONG;
      ltest_q  <= 1'b0;
      rtest_q  <= 1'b0;
      second_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          word_q   <= word_data[29:0];
          fmt_q    <= word_data[31:30];
          ltest_q  <= word_ltest;
          rtest_q  <= word_rtest;
          second_q <= 1'b0;
          state    <= S_ISSUE;
        end
        S_ISSUE: if (op_ready) state <= S_WAIT;
        S_WAIT: if (exec_done) begin
          if (first_done && go_second) begin
            second_q <= 1'b1;
            state    <= S_ISSUE;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_cycles     <= '0;
      cnt_taken_skip <= '0;
      cnt_cond_true  <= '0;
      cnt_cond_false <= '0;
    end else begin
      if (inc_cyc   && cnt_cycles     != CNT_MAX) cnt_cycles     <= cnt_cycles + 1'b1;
      if (inc_skip  && cnt_taken_skip != CNT_MAX) cnt_taken_skip <= cnt_taken_skip + 1'b1;
      if (inc_true  && cnt_cond_true  != CNT_MAX) cnt_cond_true  <= cnt_cond_true + 1'b1;
      if (inc_false && cnt_cond_false != CNT_MAX) cnt_cond_false <= cnt_cond_false + 1'b1;
    end
  end
endmodule

// File: rtl/slot_dispatcher_chk.sv
module slot_dispatcher_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             word_valid,
  input logic             word_ready,
  input logic [31:0]      word_data,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_tag,
  input logic [29:0]      op_bits,
  input logic [CNT_W-1:0] cnt_cycles,
  input logic [CNT_W-1:0] cnt_taken_skip,
  input logic [CNT_W-1:0] cnt_cond_true,
  input logic [CNT_W-1:0] cnt_cond_false
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    op_valid && !op_ready |=> op_valid && $stable(op_tag) && $stable(op_bits));

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(word_ready && op_valid));

  p_long_r2: assert property (@(posedge clk) disable iff (rst)
    word_valid && word_ready && word_data[31:30] == 2'b11
    |=> op_valid && op_tag == 2'b11 && op_bits == $past(word_data[29:0]));

  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    word_valid && word_ready && cnt_cycles != TOP |=> cnt_cycles == $past(cnt_cycles) + 1'b1);

  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_cycles == $past(cnt_cycles) || cnt_cycles == $past(cnt_cycles) + 1'b1);

  p_sat_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_cycles == TOP && cnt_taken_skip == TOP |=> cnt_cycles == TOP && cnt_taken_skip == TOP);

  p_sat_cond_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_cond_true == TOP |=> cnt_cond_true == TOP);

  p_onecond_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !(cnt_cond_true != $past(cnt_cond_true) && cnt_cond_false != $past(cnt_cond_false)));
endmodule

bind slot_dispatcher slot_dispatcher_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .op_valid(op_valid), .op_ready(op_ready),
  .op_tag(op_tag), .op_bits(op_bits), .cnt_cycles(cnt_cycles),
  .cnt_taken_skip(cnt_taken_skip), .cnt_cond_true(cnt_cond_true),
  .cnt_cond_false(cnt_cond_false)
);

// File: tb/slot_dispatcher_bench.sv
module slot_dispatcher_bench;
  localparam int CW = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rst = 1;
  logic word_valid = 0, word_ltest = 0, word_rtest = 0;
  logic [31:0] word_data = '0;
  logic word_ready, op_valid, op_ready = 0;
  logic [1:0] op_tag;
  logic [29:0] op_bits;
  logic exec_done = 0, exec_pc_changed = 0, exec_exception = 0, exec_cond_true = 0;
  logic [CW-1:0] cnt_cycles, cnt_taken_skip, cnt_cond_true, cnt_cond_false;

  always #2 clk = ~clk;

  slot_dispatcher #(.CNT_W(CW)) u_slot_dispatcher (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model
  int m_cyc, m_skip, m_true, m_false;
  logic [31:0] qop[$];
  string qreq[$];
  logic [1:0] m_fmt;
  logic [29:0] m_word;
  bit m_lt, m_rt, m_phase;

  function automatic int sinc(int v);
    return (v == MAXV) ? v : v + 1;
  endfunction

  function automatic logic [31:0] mk(bit right);
    if (m_fmt == 2'b11) return {2'b11, m_word};
    return right ? {2'b10, 15'd0, m_word[14:0]} : {2'b01, 15'd0, m_word[29:15]};
  endfunction

  function automatic string fmt_req();
    case (m_fmt)
      2'b11: return "R2";
      2'b10: return "R3";
      2'b01: return "R4";
      default: return (m_lt || m_rt) ? "R6" : "R7";
    endcase
  endfunction

  bit m_rfirst;
  always @(posedge clk) begin
    if (rst) begin
      m_cyc = 0; m_skip = 0; m_true = 0; m_false = 0;
      qop.delete(); qreq.delete(); m_phase = 0;
    end else begin
      if (word_valid && word_ready) begin
        chk(qop.size() == 0, "R9 pending ops at accept", qop.size(), 0);
        m_cyc = sinc(m_cyc);
        m_fmt = word_data[31:30]; m_word = word_data[29:0];
        m_lt = word_ltest; m_rt = word_rtest; m_phase = 0;
        m_rfirst = (m_fmt == 2'b10) || (m_fmt == 2'b00 && !m_lt && m_rt);
        qop.push_back(mk(m_rfirst)); qreq.push_back(fmt_req());
      end
      if (op_valid && op_ready) begin
        if (qop.size() == 0) chk(0, "R9 unexpected issue", {op_tag, op_bits}, 0);
        else begin
          chk({op_tag, op_bits} == qop[0], qreq[0], {op_tag, op_bits}, qop[0]);
          void'(qop.pop_front()); void'(qreq.pop_front());
        end
      end
      if (exec_done && !m_phase) begin
        m_phase = 1;
        if (m_fmt == 2'b10 || m_fmt == 2'b01) begin
          if (!exec_pc_changed && !exec_exception) begin
            qop.push_back(mk(!m_rfirst)); qreq.push_back("R5 second slot");
            m_cyc = sinc(m_cyc);
          end
          if (exec_pc_changed && !exec_exception) m_skip = sinc(m_skip);
        end else if (m_fmt == 2'b00) begin
          if (m_lt || m_rt) begin
            if (exec_cond_true) begin
              m_true = sinc(m_true);
              qop.push_back(mk(!m_rfirst)); qreq.push_back("R6 partner");
            end else m_false = sinc(m_false);
          end else if (!exec_exception) begin
            qop.push_back(mk(1)); qreq.push_back("R7 right");
          end
        end
      end
    end
  end

  // compare counters every clock, away from the edge
  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        chk(word_ready && !op_valid, "R1 idle in reset", {word_ready, op_valid}, 2);
        chk(cnt_cycles == 0 && cnt_taken_skip == 0 && cnt_cond_true == 0 && cnt_cond_false == 0,
            "R1 counters zero", cnt_cycles, 0);
      end else begin
        chk(int'(cnt_cycles) == m_cyc, "R8 cnt_cycles", cnt_cycles, m_cyc);
        chk(int'(cnt_taken_skip) == m_skip, "R5 cnt_taken_skip", cnt_taken_skip, m_skip);
        chk(int'(cnt_cond_true) == m_true, "R6 cnt_cond_true", cnt_cond_true, m_true);
        chk(int'(cnt_cond_false) == m_false, "R6 cnt_cond_false", cnt_cond_false, m_false);
        chk(!(word_ready && op_valid), "R9 exclusive", {word_ready, op_valid}, 0);
      end
    end
  end

  // execution unit model
  int rdy_cnt = 0;
  always @(negedge clk) begin
    rdy_cnt++;
    op_ready <= (rdy_cnt % 3) != 0;
  end

  always begin
    @(posedge clk);
    if (!rst && op_valid && op_ready) begin
      automatic logic [29:0] b = op_bits;
      repeat (b[4:3]) @(posedge clk);
      @(negedge clk);
      exec_done = 1; exec_pc_changed = b[0]; exec_exception = b[1]; exec_cond_true = b[2];
      @(negedge clk);
      exec_done = 0; exec_pc_changed = 0; exec_exception = 0; exec_cond_true = 0;
    end
  end

  task automatic send(input logic [31:0] w, input bit lt, input bit rt);
    bit took;
    @(negedge clk);
    word_valid = 1; word_data = w; word_ltest = lt; word_rtest = rt;
    took = 0;
    while (!took) begin
      @(posedge clk);
      took = word_ready;
    end
    @(negedge clk);
    word_valid = 0;
  endtask

  function automatic logic [31:0] pk(logic [1:0] f, logic [14:0] l, logic [14:0] r);
    return {f, l, r};
  endfunction

  logic [31:0] lfsr = 32'h1ACE_B00C;
  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    send(32'hC123_4568, 0, 0);                // R2 long
    send(pk(2'b10, 15'h1230, 15'h0450), 0, 0); // R3 both run
    send(pk(2'b10, 15'h1230, 15'h0451), 0, 0); // R5 pc changed, skip
    send(pk(2'b01, 15'h0002, 15'h0120), 0, 0); // R5 exception, no skip count
    send(pk(2'b01, 15'h0003, 15'h0120), 0, 0); // R5 pc+exception
    send(pk(2'b01, 15'h0A08, 15'h0B10), 0, 0); // R4 both run
    send(pk(2'b00, 15'h0100, 15'h0200), 0, 0); // R7 both
    send(pk(2'b00, 15'h0102, 15'h0200), 0, 0); // R7 left exception
    send(pk(2'b00, 15'h0101, 15'h0200), 0, 0); // R7 pc change does not suppress
    send(pk(2'b00, 15'h0104, 15'h0300), 1, 0); // R6 left test true
    send(pk(2'b00, 15'h0100, 15'h0300), 1, 0); // R6 left test false
    send(pk(2'b00, 15'h0500, 15'h0304), 0, 1); // R6 right test true
    send(pk(2'b00, 15'h0104, 15'h0300), 1, 1); // R6 both marked, left first
    for (int i = 0; i < 120; i++) begin      // random mix, drives R10 saturation
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr, lfsr[7], lfsr[22]);
    end
    repeat (12) @(posedge clk);
    chk(qop.size() == 0, "R9 all ops issued", qop.size(), 0);
    chk(int'(cnt_cycles) == MAXV, "R10 cycles saturated", cnt_cycles, MAXV);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule